// File: doc/BRIEF.md
# I2C Slave Clock Stretch Controller

This block sits on the slave side of a two-wire serial interface and decides when the slave must hold the clock line low. Other logic tells it when a read-data phase begins, whether the transmit buffer has run dry while the slave is sending, and whether the receive buffer is full while the slave is taking data in. The block remembers the first such condition and waits for the next falling edge of the clock line. On that edge it requests that the clock be pulled low. It then keeps the request asserted until software releases it.

Each stretch latches a 2-bit code that records why it happened, and raises a one-cycle interrupt pulse. A programmable protection period sets the minimum hold time. A release strobe that arrives before the period has elapsed is remembered and takes effect once the period is over. A separate override selects the acknowledge level that the slave drives: either the level configured by software or the default from the protocol engine.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: After synchronous reset, `scl_hold` is 0, `stretch_irq` is 0 and `cause` is 0.
- R2: While `stretch_en` is 0, `scl_hold` stays 0 whatever the other inputs do. Events seen while it is 0 are discarded and cannot start a stretch after it is set again.
- R3: A `rd_phase_start` pulse arms a stretch with cause code 0 (read-data phase start).
- R4: `tx_empty` arms a stretch with cause code 1 only while `slave_tx` is 1. `tx_empty` alone does nothing.
- R5: `rx_full` arms a stretch with cause code 2 only while `slave_rx` is 1.
- R6: When several conditions are present in the same cycle, code 0 beats code 1, and code 1 beats code 2.
- R7: A stretch begins one cycle after the first `scl_fall` that is sampled at least one cycle after the arming event. A falling edge in the same cycle as the event does not start it.
- R8: `stretch_irq` is high for exactly one cycle: the first cycle in which `scl_hold` is high.
- R9: `cause` is loaded when a stretch begins and keeps its value through the stretch, after the release and until the next stretch begins.
- R10: A `sw_clear` pulse releases an active stretch. A pulse while no stretch is active has no effect on later stretches.
- R11: With protection value P, where the clear arrives in hold cycle k (counted from 0), `scl_hold` stays high for max(P,k)+1 cycles.
- R12: `ack_level` equals `ack_ovr_level` when `ack_ovr_en` is 1, and `ack_default` otherwise.
- R13: Clearing `stretch_en` during a stretch drops `scl_hold` in the same cycle. The stretch does not resume when the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| stretch_en | input | 1 | Enables clock stretching |
| rd_phase_start | input | 1 | One-cycle pulse at the start of a read-data phase |
| slave_tx | input | 1 | Slave is currently transmitting |
| tx_empty | input | 1 | Transmit buffer is empty |
| slave_rx | input | 1 | Slave is currently receiving |
| rx_full | input | 1 | Receive buffer is full |
| scl_fall | input | 1 | One-cycle pulse on a falling clock-line edge |
| sw_clear | input | 1 | Software release strobe |
| protect_period | input | PROT_W | Minimum hold cycles before a release takes effect |
| ack_ovr_en | input | 1 | Selects the configured acknowledge level |
| ack_ovr_level | input | 1 | Configured acknowledge level |
| ack_default | input | 1 | Acknowledge level from the protocol engine |
| scl_hold | output | 1 | Request to pull the clock line low |
| cause | output | 2 | Reason for the latest stretch: 0 read start, 1 transmit empty, 2 receive full |
| stretch_irq | output | 1 | One-cycle pulse when a stretch begins |
| ack_level | output | 1 | Acknowledge level to drive |

## Verification
An arm flag that is stale or wrongly cleared shows up at the next `scl_fall`. `scl_hold` then rises when it should stay low, or stays low when it should rise, so the error is visible one cycle after the edge. A broken hold counter or a lost pending clear changes the measured hold length against max(P,k)+1, which exposes it at the release. A cause register that is loaded at the wrong time shows as a changed `cause` during or after a hold. A wrong interrupt shows as a pulse in any cycle other than the first hold cycle.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

    typedef enum logic [1:0] {
        CAUSE_RD_START = 2'd0,
        CAUSE_TX_EMPTY = 2'd1,
        CAUSE_RX_FULL  = 2'd2
    } cause_e;

    typedef struct packed {
        logic   valid;
        cause_e cause;
    } stretch_req_t;

    // Fixed priority: read start, then transmit empty, then receive full.
    function automatic stretch_req_t pick_cause(input logic rd, input logic txe, input logic rxf);
        stretch_req_t r;
        r.valid = rd | txe | rxf;
        if (rd)       r.cause = CAUSE_RD_START;
        else if (txe) r.cause = CAUSE_TX_EMPTY;
        else          r.cause = CAUSE_RX_FULL;
        return r;
    endfunction

endpackage

// File: rtl/stretch_arm.sv
module stretch_arm
    import stretch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   holding,
    input  logic   scl_fall,
    input  logic   rd_start,
    input  logic   tx_starved,
    input  logic   rx_blocked,
    output logic   start,
    output cause_e start_cause
);

    stretch_req_t armed_q;
    stretch_req_t seen;

    always_comb seen = pick_cause(rd_start, tx_starved, rx_blocked);

    assign start       = armed_q.valid & scl_fall & enable & ~holding;
    assign start_cause = armed_q.cause;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            armed_q <= '0;
        end else if (start) begin
            armed_q.valid <= 1'b0;
        end else if (!armed_q.valid && !holding) begin
            armed_q <= seen;
        end
    end

    // An armed request survives until a falling edge consumes it (R7).
    assert_arm_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (armed_q.valid && enable && !scl_fall) |=> armed_q.valid);

endmodule

// File: rtl/stretch_hold.sv
module stretch_hold
    import stretch_pkg::*;
#(
    parameter int PROT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  cause_e            start_cause,
    input  logic              sw_clear,
    input  logic [PROT_W-1:0] protect,
    output logic              hold,
    output cause_e            cause,
    output logic              irq
);

    localparam logic [PROT_W-1:0] CNT_MAX = {PROT_W{1'b1}};

    logic              hold_q;
    logic              pend_q;
    logic              irq_q;
    logic [PROT_W-1:0] cnt_q;
    cause_e            cause_q;
    logic              release_now;

    assign release_now = hold_q & (sw_clear | pend_q) & (cnt_q >= protect);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= 1'b0;
            pend_q  <= 1'b0;
            irq_q   <= 1'b0;
            cnt_q   <= '0;
            cause_q <= CAUSE_RD_START;
        end else begin
            irq_q <= start;
            if (!enable) begin
                hold_q <= 1'b0;
                pend_q <= 1'b0;
            end else if (start) begin
                hold_q  <= 1'b1;
                pend_q  <= 1'b0;
                cnt_q   <= '0;
                cause_q <= start_cause;
            end else if (release_now) begin
                hold_q <= 1'b0;
                pend_q <= 1'b0;
            end else if (hold_q) begin
                if (sw_clear)        pend_q <= 1'b1;
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign hold  = hold_q;
    assign cause = cause_q;
    assign irq   = irq_q;

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    assert_irq_on_hold_R8: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> hold_q);

    assert_cause_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_q |-> $stable(cause_q));

    assert_protect_kept_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(hold_q) && $past(enable)) |-> ($past(cnt_q) >= $past(protect)));

endmodule

// File: rtl/ack_select.sv
module ack_select (
    input  logic ovr_en,
    input  logic ovr_level,
    input  logic dflt,
    output logic level
);

    assign level = ovr_en ? ovr_level : dflt;

endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl
    import stretch_pkg::*;
#(
    parameter int PROT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stretch_en,
    input  logic              rd_phase_start,
    input  logic              slave_tx,
    input  logic              tx_empty,
    input  logic              slave_rx,
    input  logic              rx_full,
    input  logic              scl_fall,
    input  logic              sw_clear,
    input  logic [PROT_W-1:0] protect_period,
    input  logic              ack_ovr_en,
    input  logic              ack_ovr_level,
    input  logic              ack_default,
    output logic              scl_hold,
    output logic [1:0]        cause,
    output logic              stretch_irq,
    output logic              ack_level
);

    logic   start;
    cause_e start_cause;
    logic   hold;
    cause_e cause_q;

    stretch_arm u_arm (
        .clk        (clk),
        .rst        (rst),
        .enable     (stretch_en),
        .holding    (hold),
        .scl_fall   (scl_fall),
        .rd_start   (rd_phase_start),
        .tx_starved (slave_tx & tx_empty),
        .rx_blocked (slave_rx & rx_full),
        .start      (start),
        .start_cause(start_cause)
    );

    stretch_hold #(.PROT_W(PROT_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .enable     (stretch_en),
        .start      (start),
        .start_cause(start_cause),
        .sw_clear   (sw_clear),
        .protect    (protect_period),
        .hold       (hold),
        .cause      (cause_q),
        .irq        (stretch_irq)
    );

    ack_select u_ack (
        .ovr_en   (ack_ovr_en),
        .ovr_level(ack_ovr_level),
        .dflt     (ack_default),
        .level    (ack_level)
    );

    assign scl_hold = hold & stretch_en;
    assign cause    = cause_q;

    // Pull-low only ever begins right after a falling clock edge (R7).
    assert_hold_after_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> $past(scl_fall));

endmodule

// File: tb/i2c_stretch_ctrl_bench.sv
module i2c_stretch_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       stretch_en, rd_phase_start, slave_tx, tx_empty, slave_rx, rx_full;
    logic       scl_fall, sw_clear, ack_ovr_en, ack_ovr_level, ack_default;
    logic [9:0] protect_period;
    logic       scl_hold, stretch_irq, ack_level;
    logic [1:0] cause;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    i2c_stretch_ctrl u_i2c_stretch_ctrl (
        .clk(clk), .rst(rst), .stretch_en(stretch_en), .rd_phase_start(rd_phase_start),
        .slave_tx(slave_tx), .tx_empty(tx_empty), .slave_rx(slave_rx), .rx_full(rx_full),
        .scl_fall(scl_fall), .sw_clear(sw_clear), .protect_period(protect_period),
        .ack_ovr_en(ack_ovr_en), .ack_ovr_level(ack_ovr_level), .ack_default(ack_default),
        .scl_hold(scl_hold), .cause(cause), .stretch_irq(stretch_irq), .ack_level(ack_level)
    );

    function automatic int exp_len(input int p, input int k);
        return ((p > k) ? p : k) + 1;
    endfunction

    function automatic logic exp_ack(input logic en, input logic lvl, input logic d);
        return en ? lvl : d;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rd_phase_start = 0; slave_tx = 0; tx_empty = 0; slave_rx = 0; rx_full = 0;
        scl_fall = 0; sw_clear = 0;
    endtask

    task automatic run_stretch(input int kind, input int p, input int k,
                               output int len, output int c0, output int irq0,
                               output int irq_late, output int cause_bad);
        protect_period = p[9:0];
        case (kind)
            0: rd_phase_start = 1;
            1: begin slave_tx = 1; tx_empty = 1; end
            default: begin slave_rx = 1; rx_full = 1; end
        endcase
        tick();
        idle_inputs();
        scl_fall = 1;
        tick();
        scl_fall = 0;
        c0 = cause; irq0 = stretch_irq; irq_late = 0; cause_bad = 0; len = 0;
        for (int i = 0; i < 4000 && scl_hold; i++) begin
            len++;
            if (i > 0 && stretch_irq) irq_late = 1;
            if (cause != kind[1:0]) cause_bad = 1;
            sw_clear = (i == k);
            tick();
            sw_clear = 0;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len, c0, irq0, irql, cbad, seed;
        seed = $urandom(32'd20240917);
        rst = 1; stretch_en = 0; protect_period = 0;
        ack_ovr_en = 0; ack_ovr_level = 0; ack_default = 0;
        idle_inputs();
        tick(); tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(scl_hold == 0, "R1 hold", scl_hold, 0);
        chk(stretch_irq == 0, "R1 irq", stretch_irq, 0);
        chk(cause == 0, "R1 cause", cause, 0);

        // R2: disabled, events and edges ignored, events forgotten
        rd_phase_start = 1; slave_tx = 1; tx_empty = 1; tick();
        idle_inputs(); scl_fall = 1; tick(); scl_fall = 0; tick();
        chk(scl_hold == 0, "R2 disabled hold", scl_hold, 0);
        stretch_en = 1; tick();
        scl_fall = 1; tick(); scl_fall = 0; tick();
        chk(scl_hold == 0, "R2 stale event", scl_hold, 0);

        // R4: tx_empty without slave_tx does not arm
        tx_empty = 1; slave_rx = 1; tick(); idle_inputs();
        scl_fall = 1; tick(); scl_fall = 0; tick();
        chk(scl_hold == 0, "R4 tx_empty alone", scl_hold, 0);

        // R7: event and fall together do not start; later fall does
        rd_phase_start = 1; scl_fall = 1; tick(); idle_inputs();
        chk(scl_hold == 0, "R7 same-cycle fall", scl_hold, 0);
        tick(); tick();
        chk(scl_hold == 0, "R7 waits for fall", scl_hold, 0);
        scl_fall = 1; tick(); scl_fall = 0;
        chk(scl_hold == 1, "R7 hold after fall", scl_hold, 1);
        chk(stretch_irq == 1, "R8 irq at start", stretch_irq, 1);
        protect_period = 0; sw_clear = 1; tick(); sw_clear = 0;
        chk(scl_hold == 0, "R10 release", scl_hold, 0);
        chk(stretch_irq == 0, "R8 irq one cycle", stretch_irq, 0);

        // R6 priority
        rd_phase_start = 1; slave_tx = 1; tx_empty = 1; slave_rx = 1; rx_full = 1; tick();
        idle_inputs(); scl_fall = 1; tick(); scl_fall = 0;
        chk(cause == 0, "R6 all three", cause, 0);
        sw_clear = 1; tick(); sw_clear = 0;
        slave_tx = 1; tx_empty = 1; slave_rx = 1; rx_full = 1; tick();
        idle_inputs(); scl_fall = 1; tick(); scl_fall = 0;
        chk(cause == 1, "R6 tx over rx", cause, 1);
        sw_clear = 1; tick(); sw_clear = 0;

        // R10: clear while idle has no effect on next stretch
        tick(); sw_clear = 1; tick(); sw_clear = 0; tick();
        run_stretch(2, 0, 3, len, c0, irq0, irql, cbad);
        chk(len == exp_len(0, 3), "R10 idle clear ignored", len, exp_len(0, 3));
        chk(c0 == 2, "R5 cause rx full", c0, 2);
        // R9: cause persists after release
        tick(); tick(); tick();
        chk(cause == 2, "R9 cause kept", cause, 2);

        // R13: enable drop during hold
        rd_phase_start = 1; tick(); idle_inputs();
        scl_fall = 1; tick(); scl_fall = 0;
        chk(scl_hold == 1, "R13 hold active", scl_hold, 1);
        stretch_en = 0; #1;
        chk(scl_hold == 0, "R13 same-cycle drop", scl_hold, 0);
        tick(); stretch_en = 1; tick(); tick();
        chk(scl_hold == 0, "R13 no resume", scl_hold, 0);

        // R11 directed: early clear with protection
        run_stretch(1, 5, 0, len, c0, irq0, irql, cbad);
        chk(len == exp_len(5, 0), "R11 early clear", len, exp_len(5, 0));
        chk(c0 == 1, "R4 cause tx empty", c0, 1);
        run_stretch(0, 3, 7, len, c0, irq0, irql, cbad);
        chk(len == exp_len(3, 7), "R11 late clear", len, exp_len(3, 7));
        chk(c0 == 0, "R3 cause read start", c0, 0);

        // Random stretches
        for (int it = 0; it < 40; it++) begin
            int kind, p, k;
            kind = int'($urandom % 3);
            p = int'($urandom % 21);
            k = int'($urandom % 21);
            run_stretch(kind, p, k, len, c0, irq0, irql, cbad);
            chk(len == exp_len(p, k), "R11 random length", len, exp_len(p, k));
            chk(c0 == kind, "R3 R4 R5 random cause", c0, kind);
            chk(irq0 == 1 && irql == 0, "R8 random irq", irql, 0);
            chk(cbad == 0, "R9 random cause stable", cbad, 0);
            for (int g = 0; g < int'($urandom % 3); g++) tick();
        end

        // R12 acknowledge select, all combinations
        for (int v = 0; v < 8; v++) begin
            ack_ovr_en = v[2]; ack_ovr_level = v[1]; ack_default = v[0]; #1;
            chk(ack_level == exp_ack(v[2], v[1], v[0]), "R12 ack",
                ack_level, exp_ack(v[2], v[1], v[0]));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule